// File: doc/BRIEF.md
# Clock Frequency Select Controller

This block decides which frequency-select code a clock generator runs at. After reset it waits for a power-good indication. On the first clock cycle in which power-good is high, it captures five hardware strap inputs and a drive-strength strap, and it holds them until the next reset. Software can take over through a small register file. One control byte carries a software frequency code, an override bit and a spread-spectrum enable. The bits of the software code are not contiguous in that byte.

Other registers hold enables for three CPU clock pairs, a watchdog reload value and a fallback setting. The watchdog counts down and is restarted by any register write. When it expires, it puts the frequency back to either the hardware straps or a software fallback code. An active-low, open-drain-style reset output is pulled low for a fixed number of cycles after each watchdog expiry, and again whenever the effective frequency code changes. The PLL and the divider network sit outside this block.

Top module: `freqSelect`

## Requirements
- R1: On the first clock edge after reset at which `pwrGood` is 1, `strapSel` and `multSelIn` are captured. The captured values then stay constant until `rstN` is asserted, and later `pwrGood` pulses and strap changes have no effect. `driveSel` shows the captured `multSelIn`. Before capture, both values read 0.
- R2: Register 0 (control byte) resets to 0x00 and is laid out as follows: bit 7 = code bit 3, bit 6 = code bit 2, bit 5 = code bit 1, bit 4 = code bit 0, bit 3 = override, bit 2 = code bit 4, bit 1 = spread enable, bit 0 reserved. The reserved bit always reads 0 and ignores writes. `spreadEn` follows bit 1.
- R3: `effCode` equals the captured straps when override is 0, and equals the software code from register 0 when override is 1.
- R4: In register 1, bits 7:5 drive `cpuClkEn[2:0]` and reset to 1. Bits 4:0 read the captured straps and ignore writes.
- R5: Register 2 (reset 0) sets the watchdog period. Writing value V at a clock edge makes the watchdog expire V*4 cycles later. Any register write restarts the count from the current value. A value of 0 disables the watchdog.
- R6: Register 3 uses bit 7 to select the software fallback and bits 4:0 for the fallback code; bits 6:5 read 0. On expiry with bit 7 = 1, register 0 takes the fallback code and override becomes 1. With bit 7 = 0, override is cleared and the other fields are kept.
- R7: A watchdog expiry drives `sysRstN` low for 8 cycles, starting in the cycle after the expiry edge. `sysRstN` is otherwise 1 (released).
- R8: Once the straps have been captured, a change of `effCode` drives `sysRstN` low for 8 cycles, starting one cycle after the change. Writes that leave `effCode` unchanged, and the strap capture itself, cause no pulse.
- R9: A new pulse event during a pulse restarts the 8-cycle count. An expiry that also changes the code therefore holds `sysRstN` low for 9 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrGood | input | 1 | Power-good strobe, active high |
| strapSel | input | 5 | Hardware frequency-select straps |
| multSelIn | input | 1 | Drive-strength strap |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register address (0..3) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr` (combinational) |
| effCode | output | 5 | Effective frequency-select code |
| spreadEn | output | 1 | Spread-spectrum enable |
| cpuClkEn | output | 3 | CPU clock pair enables |
| driveSel | output | 1 | Captured drive-strength strap |
| sysRstN | output | 1 | System reset, 0 = drive low, 1 = release |

## Verification
The bench probes each corner case with a directed scenario.

- Strap capture is followed by a second power-good pulse with different straps. A design that samples on level rather than once would change the code and emit a spurious reset.
- The software code is written with bit 4 set and with the reserved bit set. This exposes a wrong field order or a writable reserved bit.
- The length of each reset pulse is counted in cycles. This separates expiry alone (8 cycles), expiry with a code change (9), a code-change write (8), two events close together (11), and rewrites that keep the code (0). A pulse generator that does not restart, or a change detector that fires on every write, gives the wrong count.
- Watchdog expiry is timed to the exact edge, both with and without an intervening write. A write that fails to restart the count, or an off-by-one period, moves the fallback by a cycle.

// File: rtl/freqSelectPkg.sv
package freqSelectPkg;
  localparam int CODE_W = 5;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_OUTEN = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_WDOG  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FBACK = 2'd3;

  // control byte field positions (decoded by software, so fixed)
  localparam int CB_CODE_LO  = 4; // code bits 3:0 live at 7:4
  localparam int CB_OVERRIDE = 3;
  localparam int CB_CODE_HI  = 2; // code bit 4
  localparam int CB_SPREAD   = 1;

  localparam int FB_SOFT = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic wdTimeout;
  } ctrlStrobe_t;
endpackage

// File: rtl/freqSelectDatapath.sv
module freqSelectDatapath
  import freqSelectPkg::*;
#(
  parameter int CPU_PAIRS = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrGood,
  input  logic [CODE_W-1:0]    strapSel,
  input  logic                 multSelIn,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [BYTE_W-1:0]    regWdata,
  input  ctrlStrobe_t          strobe,
  output logic [BYTE_W-1:0]    regRdata,
  output logic [CODE_W-1:0]    effCode,
  output logic                 spreadEn,
  output logic [CPU_PAIRS-1:0] cpuClkEn,
  output logic                 driveSel,
  output logic [BYTE_W-1:0]    wdReload,
  output logic [BYTE_W-1:0]    wdLoadVal,
  output logic                 codeChanged
);
  localparam int EN_TOP = BYTE_W - 1;

  logic [CODE_W-1:0]    strapLat;
  logic                 multLat;
  logic                 locked;
  logic                 lockedDly;
  logic [CODE_W-1:0]    selCode;
  logic                 override;
  logic                 spread;
  logic [CPU_PAIRS-1:0] cpuEn;
  logic                 fbSoft;
  logic [CODE_W-1:0]    fbCode;
  logic [CODE_W-1:0]    codeSeen;

  logic wrCtrl, wrOuten, wrWdog, wrFback;
  assign wrCtrl  = regWe && (regAddr == ADDR_CTRL);
  assign wrOuten = regWe && (regAddr == ADDR_OUTEN);
  assign wrWdog  = regWe && (regAddr == ADDR_WDOG);
  assign wrFback = regWe && (regAddr == ADDR_FBACK);

  // next reload value, so a write restarts with the value it writes
  assign wdLoadVal = wrWdog ? regWdata : wdReload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapLat  <= '0;
      multLat   <= 1'b0;
      locked    <= 1'b0;
      lockedDly <= 1'b0;
      selCode   <= '0;
      override  <= 1'b0;
      spread    <= 1'b0;
      cpuEn     <= '1;
      wdReload  <= '0;
      fbSoft    <= 1'b0;
      fbCode    <= '0;
      codeSeen  <= '0;
    end else begin
      if (pwrGood && !locked) begin
        strapLat <= strapSel;
        multLat  <= multSelIn;
        locked   <= 1'b1;
      end
      lockedDly <= locked;
      codeSeen  <= effCode;
      if (wrCtrl) begin
        selCode  <= {regWdata[CB_CODE_HI], regWdata[CB_CODE_LO +: 4]};
        override <= regWdata[CB_OVERRIDE];
        spread   <= regWdata[CB_SPREAD];
      end else if (strobe.wdTimeout) begin
        if (fbSoft) begin
          selCode  <= fbCode;
          override <= 1'b1;
        end else begin
          override <= 1'b0;
        end
      end
      if (wrOuten) cpuEn <= regWdata[EN_TOP -: CPU_PAIRS];
      wdReload <= wdLoadVal;
      if (wrFback) begin
        fbSoft <= regWdata[FB_SOFT];
        fbCode <= regWdata[CODE_W-1:0];
      end
    end
  end

  assign effCode     = override ? selCode : strapLat;
  assign codeChanged = lockedDly && (effCode != codeSeen);
  assign spreadEn    = spread;
  assign cpuClkEn    = cpuEn;
  assign driveSel    = multLat;

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[CB_CODE_LO +: 4] = selCode[3:0];
        regRdata[CB_OVERRIDE]     = override;
        regRdata[CB_CODE_HI]      = selCode[4];
        regRdata[CB_SPREAD]       = spread;
      end
      ADDR_OUTEN: begin
        regRdata[EN_TOP -: CPU_PAIRS] = cpuEn;
        regRdata[CODE_W-1:0]          = strapLat;
      end
      ADDR_WDOG: regRdata = wdReload;
      default: begin
        regRdata[FB_SOFT]     = fbSoft;
        regRdata[CODE_W-1:0]  = fbCode;
      end
    endcase
  end

  assert_straps_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(strapLat) && $stable(multLat)));

  assert_hw_fallback_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wdTimeout && !fbSoft && !wrCtrl) |=> !override);

  assert_sw_fallback_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wdTimeout && fbSoft && !wrCtrl) |=> (override && selCode == $past(fbCode)));
endmodule

// File: rtl/freqSelectControl.sv
module freqSelectControl
  import freqSelectPkg::*;
#(
  parameter int WDOG_SHIFT = 2,
  parameter int PULSE_LEN  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              anyWrite,
  input  logic [BYTE_W-1:0] wdReload,
  input  logic [BYTE_W-1:0] wdLoadVal,
  input  logic              codeChanged,
  output ctrlStrobe_t       strobe,
  output logic              sysRstN
);
  localparam int CNT_W   = BYTE_W + WDOG_SHIFT;
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0]   wdCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               tmo;
  logic               trigger;

  assign tmo     = (wdCnt == CNT_W'(1)) && !anyWrite;
  assign trigger = tmo || codeChanged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
    end else if (anyWrite) begin
      wdCnt <= CNT_W'(wdLoadVal) << WDOG_SHIFT;
    end else if (tmo) begin
      wdCnt <= CNT_W'(wdReload) << WDOG_SHIFT;
    end else if (wdCnt != '0) begin
      wdCnt <= wdCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (trigger) begin
      pulseCnt <= PULSE_W'(PULSE_LEN);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign strobe.wdTimeout = tmo;
  assign sysRstN          = (pulseCnt == '0);

  assert_wdog_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wdReload == '0) |-> (wdCnt == '0));

  assert_tmo_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    tmo |=> !sysRstN);

  assert_change_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    codeChanged |=> !sysRstN);

  assert_no_stray_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRstN) |-> $past(tmo || codeChanged));
endmodule

// File: rtl/freqSelect.sv
module freqSelect
  import freqSelectPkg::*;
#(
  parameter int CPU_PAIRS  = 3,
  parameter int WDOG_SHIFT = 2,
  parameter int PULSE_LEN  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrGood,
  input  logic [4:0]           strapSel,
  input  logic                 multSelIn,
  input  logic                 regWe,
  input  logic [1:0]           regAddr,
  input  logic [7:0]           regWdata,
  output logic [7:0]           regRdata,
  output logic [4:0]           effCode,
  output logic                 spreadEn,
  output logic [CPU_PAIRS-1:0] cpuClkEn,
  output logic                 driveSel,
  output logic                 sysRstN
);
  ctrlStrobe_t       strobe;
  logic [BYTE_W-1:0] wdReload;
  logic [BYTE_W-1:0] wdLoadVal;
  logic              codeChanged;

  freqSelectDatapath #(.CPU_PAIRS(CPU_PAIRS)) datapath (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .strapSel(strapSel),
    .multSelIn(multSelIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .strobe(strobe), .regRdata(regRdata),
    .effCode(effCode), .spreadEn(spreadEn), .cpuClkEn(cpuClkEn),
    .driveSel(driveSel), .wdReload(wdReload), .wdLoadVal(wdLoadVal),
    .codeChanged(codeChanged)
  );

  freqSelectControl #(.WDOG_SHIFT(WDOG_SHIFT), .PULSE_LEN(PULSE_LEN)) control (
    .clk(clk), .rstN(rstN), .anyWrite(regWe), .wdReload(wdReload),
    .wdLoadVal(wdLoadVal), .codeChanged(codeChanged), .strobe(strobe),
    .sysRstN(sysRstN)
  );
endmodule

// File: tb/freqSelect_test.sv
`timescale 1ns/1ps
module freqSelect_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrGood = 1'b0;
  logic [4:0] strapSel = 5'h00;
  logic       multSelIn = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [4:0] effCode;
  logic       spreadEn;
  logic [2:0] cpuClkEn;
  logic       driveSel;
  logic       sysRstN;

  int checks = 0;
  int failures = 0;
  int lowCnt = 0;

  always #2.5 clk = ~clk;

  freqSelect uut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .strapSel(strapSel),
    .multSelIn(multSelIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .effCode(effCode),
    .spreadEn(spreadEn), .cpuClkEn(cpuClkEn), .driveSel(driveSel),
    .sysRstN(sysRstN)
  );

  // cycles with the reset output driven low
  always @(negedge clk) if (rstN && !sysRstN) lowCnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0; regAddr = 2'd0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; #1; d = regRdata; regAddr = 2'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    logic [7:0] d;
    readReg(2'd0, d); chk("R2 ctrl reset", d, 8'h00);
    readReg(2'd1, d); chk("R4 outen reset", d, 8'hE0);
    readReg(2'd2, d); chk("R5 wdog reset", d, 8'h00);
    readReg(2'd3, d); chk("R6 fallback reset", d, 8'h00);
    chk("R4 cpuClkEn reset", cpuClkEn, 3'b111);
    chk("R3 effCode reset", effCode, 0);
    chk("R7 sysRstN released", sysRstN, 1);
  endtask

  task automatic testStraps();
    logic [7:0] d;
    strapSel = 5'h16; multSelIn = 1'b1;
    idle(3);
    chk("R1 no capture without pwrGood", effCode, 0);
    lowCnt = 0;
    @(negedge clk) pwrGood = 1'b1;
    @(negedge clk) pwrGood = 1'b0;
    strapSel = 5'h09; multSelIn = 1'b0;
    idle(3);
    @(negedge clk) pwrGood = 1'b1;
    idle(2);
    @(negedge clk) pwrGood = 1'b0;
    idle(12);
    chk("R1 straps captured once", effCode, 5'h16);
    chk("R1 driveSel captured", driveSel, 1);
    readReg(2'd1, d); chk("R4 straps readback", d, 8'hF6);
    chk("R8 no pulse on capture", lowCnt, 0);
  endtask

  task automatic testOverride();
    logic [7:0] d;
    lowCnt = 0;
    writeReg(2'd0, 8'h9B);
    readReg(2'd0, d); chk("R2 reserved bit reads 0", d, 8'h9A);
    chk("R3 software code", effCode, 5'h09);
    chk("R2 spreadEn", spreadEn, 1);
    idle(20); chk("R8 change pulse length", lowCnt, 8);
    lowCnt = 0;
    writeReg(2'd0, 8'h0C);
    chk("R2 code bit 4 position", effCode, 5'h10);
    chk("R2 spread off", spreadEn, 0);
    idle(20); chk("R8 pulse on bit4 change", lowCnt, 8);
  endtask

  task automatic testNoChange();
    logic [7:0] d;
    lowCnt = 0;
    writeReg(2'd0, 8'h0C);
    writeReg(2'd1, 8'h5F);
    idle(20);
    chk("R8 no pulse when code kept", lowCnt, 0);
    chk("R4 cpuClkEn written", cpuClkEn, 3'b010);
    readReg(2'd1, d); chk("R4 strap bits read-only", d, 8'h56);
    lowCnt = 0;
    writeReg(2'd0, 8'h00);
    chk("R3 back to straps", effCode, 5'h16);
    idle(20); chk("R8 pulse on override clear", lowCnt, 8);
  endtask

  task automatic testRestart();
    lowCnt = 0;
    writeReg(2'd0, 8'h08);
    idle(2);
    writeReg(2'd0, 8'h18);
    idle(25);
    chk("R9 restarted pulse length", lowCnt, 11);
    chk("R3 code after second write", effCode, 5'h01);
    writeReg(2'd0, 8'h00);
    idle(20);
  endtask

  task automatic testSoftFallback();
    logic [7:0] d;
    writeReg(2'd3, 8'hE3);
    readReg(2'd3, d); chk("R6 fallback readback", d, 8'h83);
    lowCnt = 0;
    writeReg(2'd2, 8'h02);
    idle(7);
    chk("R5 no expiry before 8 cycles", effCode, 5'h16);
    idle(1);
    chk("R5 expiry at 8 cycles", effCode, 5'h03);
    chk("R7 low after expiry", sysRstN, 0);
    writeReg(2'd2, 8'h00);
    idle(20);
    chk("R9 expiry plus change length", lowCnt, 9);
    readReg(2'd0, d); chk("R6 soft fallback loaded", d, 8'h38);
  endtask

  task automatic testHwFallback();
    logic [7:0] d;
    writeReg(2'd3, 8'h00);
    lowCnt = 0;
    writeReg(2'd2, 8'h01);
    idle(3);
    chk("R5 period 4 not yet", effCode, 5'h03);
    idle(1);
    chk("R6 hw fallback", effCode, 5'h16);
    writeReg(2'd2, 8'h00);
    idle(20);
    chk("R7 hw fallback pulse", lowCnt, 9);
    readReg(2'd0, d); chk("R6 override cleared only", d, 8'h30);
    idle(40);
    chk("R5 disabled by zero", effCode, 5'h16);
  endtask

  task automatic testWriteRestart();
    logic [7:0] d;
    lowCnt = 0;
    writeReg(2'd2, 8'h02);
    idle(4);
    writeReg(2'd3, 8'h96);
    idle(7);
    chk("R5 write restarted count", sysRstN, 1);
    chk("R5 no early expiry", lowCnt, 0);
    idle(1);
    chk("R7 expiry after restart", sysRstN, 0);
    writeReg(2'd2, 8'h00);
    idle(20);
    chk("R7 expiry alone length", lowCnt, 8);
    readReg(2'd0, d); chk("R6 fallback code with bit4", d, 8'h6C);
    chk("R3 code unchanged", effCode, 5'h16);
  endtask

  task automatic testReapply();
    logic [7:0] d;
    @(negedge clk) rstN = 1'b0;
    strapSel = 5'h03; multSelIn = 1'b0;
    idle(2);
    readReg(2'd0, d); chk("R2 ctrl after reset", d, 8'h00);
    readReg(2'd1, d); chk("R1 straps cleared", d, 8'hE0);
    @(negedge clk) rstN = 1'b1;
    lowCnt = 0;
    @(negedge clk) pwrGood = 1'b1;
    @(negedge clk) pwrGood = 1'b0;
    idle(12);
    chk("R1 recapture after reset", effCode, 5'h03);
    chk("R1 driveSel recaptured", driveSel, 0);
    chk("R8 no pulse after recapture", lowCnt, 0);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rstN = 1'b1;
    idle(1);
    testReset();
    testStraps();
    testOverride();
    testNoChange();
    testRestart();
    testSoftFallback();
    testHwFallback();
    testWriteRestart();
    testReapply();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule